// File: doc/BRIEF.md
# Top-Region Write Protection Checker

This block decides, for every write address presented to a small serial non-volatile memory, whether that write may proceed. The decision is driven by a protection scheme that covers the top of memory. The memory's highest byte serves as a control byte. Its upper bits give the base of a read-only region that ends at the last address, and one of its low bits can disarm the scheme. The block keeps a shadow copy of that byte. It combines the shadow with an external protect-enable pin and, for the largest density, with two block-select pins that supply the upper bits of the region base.

The shadow byte is loaded from a boot value while reset is held. After reset it follows every accepted write to the highest address. The permit flag is purely combinational from the address, the pins and the shadow, so the surrounding write path can use it in the same cycle as the request. A parameter selects a 512, 1024 or 2048 byte density. The two smaller densities use one control byte layout, and the largest density uses another.

Top module: `top_region_guard`

## Requirements
- R1: While `rst` is high the shadow control byte is loaded from `boot_byte`, and permit decisions after reset follow that value.
- R2: When `prot_en` is 0, `wr_permit` is 1 for every address.
- R3: When bit 2 of the shadow byte is 1, `wr_permit` is 1 for every address, whatever `prot_en` is.
- R4: When protection is armed (`prot_en` = 1 and shadow bit 2 = 0), `wr_permit` is 0 for addresses at or above the region base and 1 for addresses below it.
- R5: For the 512 and 1024 byte densities the region base is the top-256-byte origin (MEM_BYTES-256) plus 8 times shadow bits 7..3. Bits 2..0 are control bits.
- R6: For the 2048 byte density the region base is 1024 plus 256 times `blk_sel` plus 16 times shadow bits 7..4. Bits 3..0 are control bits.
- R7: `blk_sel` changes the region base in the same cycle for the 2048 byte density, and has no effect for the smaller densities.
- R8: A write with `wr_req` = 1 and `wr_permit` = 1 to the highest address loads `wr_data` into the shadow at the next clock edge. A blocked write, or a write to any other address, leaves the shadow unchanged.
- R9: While protection is armed, a write to the highest address is itself refused, so the control byte cannot be rewritten.
- R10: `wr_permit` is combinational and is valid in the same cycle as the address and pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the shadow from `boot_byte` |
| boot_byte | input | 8 | Control byte value read from the highest address at reset |
| wr_addr | input | ADDR_W | Requested write address |
| wr_req | input | 1 | Write request |
| wr_data | input | 8 | Write data, captured into the shadow on an accepted write to the top address |
| prot_en | input | 1 | Hardware protect-enable pin |
| blk_sel | input | 2 | Block-select pins, the upper region-base bits in the 2048 byte density |
| wr_permit | output | 1 | 1 when a write to `wr_addr` is allowed |

## Verification
The bench runs a 2048 byte and a 1024 byte instance side by side. It probes the exact region base and the address just below it, so a design that used > instead of >= would open the base byte, and a design that misplaced the field would move the boundary. It writes the control byte while protection is disarmed and then again while it is armed. A design that let a blocked write reach the shadow would shift the boundary on the next cycle. It also sweeps the block-select pins on both instances, to catch a larger density that ignores them and a smaller density that wrongly uses them.

// File: rtl/tr_guard_pkg.sv
package tr_guard_pkg;
    localparam int CTRL_LOCK_BIT = 2;
    localparam int WIDE_MEM_BYTES = 2048;

    typedef struct packed {
        logic [4:0] base;
        logic [2:0] ctl;
    } narrow_ctrl_t;

    typedef struct packed {
        logic [3:0] base;
        logic [3:0] ctl;
    } wide_ctrl_t;

    function automatic logic lock_armed(input logic pin, input logic [7:0] ctrl);
        return pin & ~ctrl[CTRL_LOCK_BIT];
    endfunction
endpackage

// File: rtl/tr_shadow_reg.sv
module tr_shadow_reg (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] boot_byte,
    input  logic       upd_en,
    input  logic [7:0] upd_byte,
    output logic [7:0] ctrl_byte
);
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_byte <= boot_byte;
        else if (upd_en)
            ctrl_byte <= upd_byte;
    end

    // R8: an accepted write to the top address lands in the shadow
    assert_shadow_load_R8: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> ctrl_byte == $past(upd_byte));
    // R8: without an accepted write the shadow holds
    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(ctrl_byte));
endmodule

// File: rtl/tr_bound_decode.sv
module tr_bound_decode #(
    parameter int MEM_BYTES = 2048,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic [7:0]    ctrl_byte,
    input  logic [1:0]    blk_sel,
    output logic [AW-1:0] base_addr
);
    import tr_guard_pkg::*;

    localparam bit IS_WIDE = (MEM_BYTES == WIDE_MEM_BYTES);

    generate
        if (IS_WIDE) begin : g_wide
            wide_ctrl_t fmt;
            logic [3:0] unused_ctl;
            assign fmt        = wide_ctrl_t'(ctrl_byte);
            assign unused_ctl = fmt.ctl;
            // R6/R7: one top bit, block pins, 4-bit field, 16-byte steps
            assign base_addr  = {{(AW-10){1'b1}}, blk_sel, fmt.base, 4'b0000};
        end else begin : g_narrow
            narrow_ctrl_t fmt;
            logic [2:0] unused_ctl;
            logic [1:0] unused_blk;
            assign fmt        = narrow_ctrl_t'(ctrl_byte);
            assign unused_ctl = fmt.ctl;
            assign unused_blk = blk_sel;
            // R5: inside the top 256 bytes, 8-byte steps
            assign base_addr  = {{(AW-8){1'b1}}, fmt.base, 3'b000};
        end
    endgenerate
endmodule

// File: rtl/tr_region_cmp.sv
module tr_region_cmp #(
    parameter int AW = 11
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base_addr,
    input  logic          armed,
    output logic          permit
);
    logic in_region;

    always_comb begin
        in_region = (addr >= base_addr);
        permit    = !(armed && in_region);
    end
endmodule

// File: rtl/top_region_guard.sv
module top_region_guard #(
    parameter int MEM_BYTES = 2048,
    localparam int ADDR_W = $clog2(MEM_BYTES),
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(MEM_BYTES - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        boot_byte,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_req,
    input  logic [7:0]        wr_data,
    input  logic              prot_en,
    input  logic [1:0]        blk_sel,
    output logic              wr_permit
);
    import tr_guard_pkg::*;

    logic [7:0]        ctrl_byte;
    logic [ADDR_W-1:0] base_addr;
    logic              armed;
    logic              upd_en;

    assign armed  = lock_armed(prot_en, ctrl_byte);
    assign upd_en = wr_req && wr_permit && (wr_addr == TOP_ADDR);

    tr_shadow_reg u_shadow (
        .clk       (clk),
        .rst       (rst),
        .boot_byte (boot_byte),
        .upd_en    (upd_en),
        .upd_byte  (wr_data),
        .ctrl_byte (ctrl_byte)
    );

    tr_bound_decode #(.MEM_BYTES(MEM_BYTES)) u_decode (
        .ctrl_byte (ctrl_byte),
        .blk_sel   (blk_sel),
        .base_addr (base_addr)
    );

    tr_region_cmp #(.AW(ADDR_W)) u_cmp (
        .addr      (wr_addr),
        .base_addr (base_addr),
        .armed     (armed),
        .permit    (wr_permit)
    );

    // R2: pin low opens the whole memory
    assert_pin_off_R2: assert property (@(posedge clk) disable iff (rst)
        !prot_en |-> wr_permit);
    // R3: software disarm bit opens the whole memory
    assert_soft_off_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_byte[2] |-> wr_permit);
    // R4: addresses below the decoded base remain writable
    assert_below_open_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_addr < base_addr) |-> wr_permit);
    // R9: the control byte itself is locked while armed
    assert_top_locked_R9: assert property (@(posedge clk) disable iff (rst)
        (prot_en && !ctrl_byte[2] && wr_addr == TOP_ADDR) |-> !wr_permit);
endmodule

// File: tb/top_region_guard_test.sv
module top_region_guard_test;
    logic        clk = 0;
    logic        rst;
    logic [7:0]  boot_byte;
    logic [10:0] addr_l;
    logic [9:0]  addr_m;
    logic        wr_req;
    logic [7:0]  wr_data;
    logic        prot_en;
    logic [1:0]  blk_sel;
    logic        permit_l, permit_m;

    int checks = 0;
    int fails  = 0;
    int sh_l, sh_m;
    bit done = 0;

    always #5 clk = ~clk;

    top_region_guard #(.MEM_BYTES(2048)) uut (
        .clk(clk), .rst(rst), .boot_byte(boot_byte), .wr_addr(addr_l),
        .wr_req(wr_req), .wr_data(wr_data), .prot_en(prot_en),
        .blk_sel(blk_sel), .wr_permit(permit_l));

    top_region_guard #(.MEM_BYTES(1024)) uut_mid (
        .clk(clk), .rst(rst), .boot_byte(boot_byte), .wr_addr(addr_m),
        .wr_req(wr_req), .wr_data(wr_data), .prot_en(prot_en),
        .blk_sel(blk_sel), .wr_permit(permit_m));

    function automatic int ref_permit(int mem, int sh, int a, int pen, int blk);
        int base;
        if (pen == 0 || ((sh / 4) % 2) == 1) return 1;
        if (mem == 2048) base = 1024 + blk * 256 + (sh / 16) * 16;
        else             base = mem - 256 + (sh / 8) * 8;
        return (a < base) ? 1 : 0;
    endfunction

    task automatic cmp(string tag, string who, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s permit got %0d expected %0d", tag, who, got, exp);
        end
    endtask

    task automatic do_reset(int boot);
        @(negedge clk);
        rst = 1; boot_byte = boot[7:0]; wr_req = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        sh_l = boot; sh_m = boot;
    endtask

    task automatic step(int al, int am, int req, int pen, int blk, int data, string tag);
        int el, em;
        @(negedge clk);
        addr_l = al[10:0]; addr_m = am[9:0]; wr_req = req[0];
        prot_en = pen[0]; blk_sel = blk[1:0]; wr_data = data[7:0];
        #2;
        el = ref_permit(2048, sh_l, al, pen, blk);
        em = ref_permit(1024, sh_m, am, pen, blk);
        cmp(tag, "wide", int'(permit_l), el);
        cmp(tag, "mid",  int'(permit_m), em);
        if (req != 0 && el == 1 && al == 2047) sh_l = data;
        if (req != 0 && em == 1 && am == 1023) sh_m = data;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; boot_byte = 0; addr_l = 0; addr_m = 0; wr_req = 0;
        wr_data = 0; prot_en = 0; blk_sel = 0;
        // R1: boot value 0x00 arms the base at its lowest point
        do_reset(8'h00);
        step(1023, 767, 0, 1, 0, 0, "R1");
        step(1024, 768, 0, 1, 0, 0, "R1");
        // R2: pin low opens everything, including the top byte
        step(2047, 1023, 0, 0, 0, 0, "R2");
        step(1500, 900, 0, 0, 3, 0, "R2");
        // R8: accepted write of 0x54 (bit2 = 1) to the top byte
        step(2047, 1023, 1, 0, 0, 8'h54, "R8");
        // R3: bit 2 set disarms even with the pin high
        step(2047, 1023, 0, 1, 0, 0, "R3");
        step(1600, 1000, 0, 1, 2, 0, "R3");
        // R8: write 0xA0 while disarmed; field 0xA, bits7..3 = 20
        step(2047, 1023, 1, 1, 0, 8'hA0, "R8");
        // R4/R6: wide base = 1024+160 = 1184; R5: mid base = 768+160 = 928
        step(1183, 927, 0, 1, 0, 0, "R4");
        step(1184, 928, 0, 1, 0, 0, "R4");
        step(1184, 928, 0, 1, 0, 0, "R6");
        step(1000, 927, 0, 1, 0, 0, "R5");
        // R9: top byte locked; blocked write must not reach the shadow
        step(2047, 1023, 1, 1, 0, 8'h04, "R9");
        step(1184, 928, 0, 1, 0, 0, "R8");
        step(1183, 927, 0, 1, 0, 0, "R8");
        // R7: block pins move the wide base, mid ignores them
        for (int b = 0; b < 4; b++) begin
            step(1024 + b * 256 + 159, 928, 0, 1, b, 0, "R7");
            step(1024 + b * 256 + 160, 927, 0, 1, b, 0, "R7");
        end
        // R10: permit follows address change with no clock in between
        @(negedge clk);
        addr_l = 11'd1184; prot_en = 1; blk_sel = 0;
        #1 cmp("R10", "wide", int'(permit_l), 0);
        addr_l = 11'd100;
        #1 cmp("R10", "wide", int'(permit_l), 1);
        // R1: second reset with boot 0x30 (field 3, bit2 = 0)
        do_reset(8'h30);
        step(1024 + 48 - 1, 768 + 48 - 1, 0, 1, 0, 0, "R1");
        step(1024 + 48, 768 + 48, 0, 1, 0, 0, "R1");
        // R4: mixed traffic checked against the model every cycle
        for (int i = 0; i < 400; i++) begin
            int a = $urandom_range(0, 2047);
            int top = ($urandom_range(0, 7) == 0);
            int pen = ($urandom_range(0, 3) != 0);
            if (top != 0) a = 2047;
            step(a, a % 1024 + ((top != 0) ? 1023 - (a % 1024) : 0),
                 $urandom_range(0, 1), pen, $urandom_range(0, 3),
                 $urandom_range(0, 255), "R4");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule